// File: doc/BRIEF.md
# Cache Maintenance Command Queue

This block is the register front end through which several bus masters hand maintenance work to an outer cache. A master claims the queue by writing a mode word. Then, depending on the region and destination that the mode word selects, it writes an address and a size, a way mask, or nothing more. When the claiming master has written every register its mode needs, the block issues one command to the cache array on the next cycle. It then waits for the array to report completion. If the mode word asked for notification, a sticky completion flag is raised, and software clears it by writing a one to it.

Only one master owns the queue at a time. A mode write from any other master, or any write at all while a command is in flight, is dropped, and that master sees an overrun flag. A parameter write from a master that does not own a setup is also dropped, and that master sees a setup-fault flag. Each master reads its own pair of flags. If either flag is set, the master starts again from its mode write.

A separate primitive register carries buffer commands. Writing the drain code or the prefetch-buffer flush code sends a one-cycle request to the array. Any access to the primitive register is held off until the array reports that the request has finished, so reading back the primitive register doubles as a barrier.

The queue controller has four states. Q_IDLE moves to Q_SETUP on a granted mode write that needs parameters, or straight to Q_ISSUE if the mode needs none. Q_SETUP moves to Q_ISSUE when the owner's last required parameter lands, and it re-enters itself when the owner writes a new mode word. Q_ISSUE always moves to Q_BUSY. Q_BUSY returns to Q_IDLE on done from the array. The primitive controller goes from P_IDLE to P_START when a valid code is written, from P_START to P_WAIT, and from P_WAIT back to P_IDLE on its done input.

Top module: `cache_maint_queue`

## Requirements
- R1: After reset the status register (byte offset 0x260) reads 0, no command or primitive request is driven, and every master's flag register (0x25C) reads 0.
- R2: A mode write (0x248) is granted to the writing master when the queue is idle. The mode word fields are: command code in bits 2:0, notify in bit 15, region in bits 18:17 (0 address range, 1 whole cache, 2 by way), and destination in bits 22:21 (0 LRU data, 1 LRU instruction, 2 by way). Range region needs both the address (0x24C) and the size (0x250). A by-way region or a by-way destination needs the way mask (0x258). A whole-cache region with a non-way destination needs nothing more.
- R3: The array start pulse lasts exactly one cycle. It is raised on the cycle after the owner's last required write, or after the mode write if no parameter is needed. While it is high, the array command, region, destination, address, size and ways outputs carry the owner's values.
- R4: A mode write is dropped while another master owns a setup, and also while a command is being issued or executed. The writer's overrun flag (bit 0 of 0x25C) is then set.
- R5: An address, size, mask or way write from a master that does not own an open setup is dropped and sets that master's setup-fault flag (bit 1 of 0x25C). The owner's programmed values reach the array unchanged.
- R6: Flags are kept per master. A read of 0x25C returns the reader's own pair. Both bits of a master are cleared when that master's mode write is granted.
- R7: Status bit 2 becomes 1 when the array reports done for a command whose notify bit was set, and stays 0 otherwise. Writing 1 to bit 2 clears it. Writing 0 to bit 2 leaves it unchanged.
- R8: Status bit 1 is 1 from the issue cycle until done. Status bit 0 is 1 from the grant until done. Both are 0 once the command completes.
- R9: Writing code 8 (drain) or 9 (prefetch-buffer flush) to the primitive register (0x244) gives a one-cycle primitive request carrying that code. Any other code starts nothing.
- R10: While a primitive request is outstanding, any access to 0x244 is stalled (ack low) until done returns from the array. A read of 0x244 returns the last code written there.
- R11: A mode write from the owner during setup restarts the setup. The new mode's needs replace the old ones, and parameters already written under the old mode do not count toward the new mode's needs.
- R12: The mode, address, size, mask and way registers read back the owner's last accepted values at their offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_id | input | ID_W | Identity of the requesting master |
| bus_addr | input | OFS_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Access accepted this cycle |
| bus_rdata | output | 32 | Read data, valid with ack |
| arr_start | output | 1 | One-cycle command issue to the cache array |
| arr_cmd | output | 3 | Command code |
| arr_region | output | 2 | Region selector |
| arr_dest | output | 2 | Destination selector |
| arr_addr | output | 32 | Range start address |
| arr_size | output | 32 | Range size |
| arr_mask | output | 32 | Address mask |
| arr_ways | output | NUM_WAYS | Way mask |
| arr_done | input | 1 | Command finished |
| prim_start | output | 1 | One-cycle primitive request |
| prim_code | output | 4 | Primitive code (8 drain, 9 prefetch-buffer flush) |
| prim_done | input | 1 | Primitive finished |

## Verification
The bench builds the block with four masters and eight ways. Four masters are enough for one owner, an intruder during setup, and a third master rejected while a command is in flight, each under its own ID, so the per-master flags can be told apart. Eight ways let the bench check way masks in both nibbles at the array port. The array model's latency can be changed, which keeps commands in flight long enough to test rejection and the primitive barrier stall.

// File: rtl/cmq_pkg.sv
package cmq_pkg;

    // Register byte offsets; software decodes these, so they are fixed.
    localparam logic [11:0] OFS_PRIM  = 12'h244;
    localparam logic [11:0] OFS_MODE  = 12'h248;
    localparam logic [11:0] OFS_ADDR  = 12'h24C;
    localparam logic [11:0] OFS_SIZE  = 12'h250;
    localparam logic [11:0] OFS_MASK  = 12'h254;
    localparam logic [11:0] OFS_WAYS  = 12'h258;
    localparam logic [11:0] OFS_FLAGS = 12'h25C;
    localparam logic [11:0] OFS_STAT  = 12'h260;

    // Mode word field positions
    localparam int DEST_LSB   = 21;
    localparam int REGION_LSB = 17;
    localparam int NOTIFY_BIT = 15;

    localparam logic [3:0] PRIM_DRAIN     = 4'h8;
    localparam logic [3:0] PRIM_PFB_FLUSH = 4'h9;

    typedef enum logic [1:0] {
        RG_RANGE = 2'd0,
        RG_ALL   = 2'd1,
        RG_WAY   = 2'd2,
        RG_RSVD  = 2'd3
    } region_e;

    typedef enum logic [1:0] {
        DS_LRU_DATA = 2'd0,
        DS_LRU_INST = 2'd1,
        DS_WAY      = 2'd2,
        DS_RSVD     = 2'd3
    } dest_e;

    typedef enum logic [1:0] {
        Q_IDLE,
        Q_SETUP,
        Q_ISSUE,
        Q_BUSY
    } qstate_e;

    typedef enum logic [1:0] {
        P_IDLE,
        P_START,
        P_WAIT
    } pstate_e;

    typedef struct packed {
        logic [2:0] cmd;
        region_e    region;
        dest_e      dest;
        logic       notify;
    } mode_t;

    function automatic mode_t unpack_mode(input logic [31:0] w);
        mode_t m;
        m.cmd    = w[2:0];
        m.region = region_e'(w[REGION_LSB+1:REGION_LSB]);
        m.dest   = dest_e'(w[DEST_LSB+1:DEST_LSB]);
        m.notify = w[NOTIFY_BIT];
        return m;
    endfunction

endpackage

// File: rtl/cmq_flags.sv
module cmq_flags #(
    parameter int NUM_MASTERS = 4,
    parameter int ID_W        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] id,
    input  logic            set_oe,
    input  logic            set_fe,
    input  logic            clr,
    output logic [1:0]      rd_flags
);

    logic [NUM_MASTERS-1:0] oe_q;
    logic [NUM_MASTERS-1:0] fe_q;

    generate
        for (genvar i = 0; i < NUM_MASTERS; i++) begin : g_master
            logic sel;
            assign sel = (id == ID_W'(i));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    oe_q[i] <= 1'b0;
                    fe_q[i] <= 1'b0;
                end else if (sel && clr) begin
                    oe_q[i] <= 1'b0;
                    fe_q[i] <= 1'b0;
                end else begin
                    if (sel && set_oe) oe_q[i] <= 1'b1;
                    if (sel && set_fe) fe_q[i] <= 1'b1;
                end
            end

            // R4
            oe_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(oe_q[i]) |-> $past(set_oe && id == ID_W'(i)));
        end
    endgenerate

    always_comb begin
        if (int'(id) < NUM_MASTERS) rd_flags = {fe_q[id], oe_q[id]};
        else                        rd_flags = 2'b00;
    end

endmodule

// File: rtl/cmq_ctrl.sv
module cmq_ctrl
    import cmq_pkg::*;
#(
    parameter int ID_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] wr_id,
    input  logic            mode_wr,
    input  logic            need_addr,
    input  logic            need_ways,
    input  logic            addr_wr,
    input  logic            size_wr,
    input  logic            ways_wr,
    input  logic            mask_wr,
    input  logic            notify,
    input  logic            arr_done,
    input  logic            ef_clr,
    output logic            mode_grant,
    output logic            mode_deny,
    output logic            param_take,
    output logic            param_deny,
    output logic            arr_start,
    output logic            est,
    output logic            qst,
    output logic            ef
);

    qstate_e         st, st_n;
    logic [ID_W-1:0] owner;
    logic [2:0]      pend, pend_n;   // {ways, size, addr}
    logic            owner_hit;
    logic            param_wr;

    assign owner_hit  = (wr_id == owner);
    assign param_wr   = addr_wr | size_wr | ways_wr | mask_wr;
    assign mode_grant = mode_wr && ((st == Q_IDLE) || (st == Q_SETUP && owner_hit));
    assign mode_deny  = mode_wr && !mode_grant;
    assign param_take = param_wr && (st == Q_SETUP) && owner_hit;
    assign param_deny = param_wr && !param_take;

    // next-state logic
    always_comb begin
        st_n   = st;
        pend_n = pend;
        unique case (st)
            Q_IDLE, Q_SETUP: begin
                if (mode_grant) begin
                    pend_n = {need_ways, need_addr, need_addr};
                    st_n   = (need_ways || need_addr) ? Q_SETUP : Q_ISSUE;
                end else if (st == Q_SETUP && param_take) begin
                    pend_n = pend & ~{ways_wr, size_wr, addr_wr};
                    if (pend_n == 3'b000) st_n = Q_ISSUE;
                end
            end
            Q_ISSUE: st_n = Q_BUSY;
            Q_BUSY:  if (arr_done) st_n = Q_IDLE;
            default: st_n = Q_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= Q_IDLE;
            pend  <= 3'b000;
            owner <= '0;
        end else begin
            st   <= st_n;
            pend <= pend_n;
            if (mode_grant) owner <= wr_id;
        end
    end

    // completion flag: set wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                ef <= 1'b0;
        else if (st == Q_BUSY && arr_done && notify) ef <= 1'b1;
        else if (ef_clr)                           ef <= 1'b0;
    end

    // outputs
    always_comb begin
        arr_start = (st == Q_ISSUE);
        est       = (st == Q_ISSUE) || (st == Q_BUSY);
        qst       = (st != Q_IDLE);
    end

    // R3
    issue_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |=> !arr_start);

    // R7
    ef_from_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ef) |-> $past(arr_done));

    // R8
    busy_until_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (est && !arr_done) |=> qst);

endmodule

// File: rtl/cmq_prim.sv
module cmq_prim
    import cmq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       prim_wr,
    input  logic [3:0] wr_code,
    input  logic       prim_done,
    output logic       prim_start,
    output logic [3:0] prim_code,
    output logic       busy
);

    pstate_e    st, st_n;
    logic [3:0] code_q;
    logic       valid_code;

    assign valid_code = (wr_code == PRIM_DRAIN) || (wr_code == PRIM_PFB_FLUSH);

    always_comb begin
        st_n = st;
        unique case (st)
            P_IDLE:  if (prim_wr && valid_code) st_n = P_START;
            P_START: st_n = P_WAIT;
            P_WAIT:  if (prim_done) st_n = P_IDLE;
            default: st_n = P_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= P_IDLE;
            code_q <= 4'h0;
        end else begin
            st <= st_n;
            if (st == P_IDLE && prim_wr && valid_code) code_q <= wr_code;
        end
    end

    always_comb begin
        prim_start = (st == P_START);
        prim_code  = code_q;
        busy       = (st != P_IDLE);
    end

    // R9
    prim_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prim_start |=> !prim_start);

    // R9
    prim_code_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prim_start |-> (prim_code == PRIM_DRAIN || prim_code == PRIM_PFB_FLUSH));

endmodule

// File: rtl/cache_maint_queue.sv
module cache_maint_queue
    import cmq_pkg::*;
#(
    parameter int NUM_MASTERS = 4,
    parameter int ID_W        = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1,
    parameter int NUM_WAYS    = 8,
    parameter int OFS_W       = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ID_W-1:0]     bus_id,
    input  logic [OFS_W-1:0]    bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic                bus_ack,
    output logic [31:0]         bus_rdata,
    output logic                arr_start,
    output logic [2:0]          arr_cmd,
    output logic [1:0]          arr_region,
    output logic [1:0]          arr_dest,
    output logic [31:0]         arr_addr,
    output logic [31:0]         arr_size,
    output logic [31:0]         arr_mask,
    output logic [NUM_WAYS-1:0] arr_ways,
    input  logic                arr_done,
    output logic                prim_start,
    output logic [3:0]          prim_code,
    input  logic                prim_done
);

    localparam int WAY_PAD = 32 - NUM_WAYS;

    logic [11:0] ofs;
    logic        hit_prim, hit_mode, hit_addr, hit_size, hit_mask, hit_ways, hit_stat;
    logic        prim_busy, wr_fire;
    logic        mode_grant, mode_deny, param_take, param_deny;
    logic        est, qst, ef;
    logic [1:0]  rd_flags;
    mode_t       new_mode, cur_mode;

    logic [31:0]         mode_r, addr_r, size_r, mask_r;
    logic [NUM_WAYS-1:0] ways_r;
    logic [3:0]          prim_last;

    assign ofs      = 12'(bus_addr);
    assign hit_prim = (ofs == OFS_PRIM);
    assign hit_mode = (ofs == OFS_MODE);
    assign hit_addr = (ofs == OFS_ADDR);
    assign hit_size = (ofs == OFS_SIZE);
    assign hit_mask = (ofs == OFS_MASK);
    assign hit_ways = (ofs == OFS_WAYS);
    assign hit_stat = (ofs == OFS_STAT);

    assign bus_ack  = bus_req && !(hit_prim && prim_busy);
    assign wr_fire  = bus_req && bus_we && bus_ack;

    assign new_mode = unpack_mode(bus_wdata);
    assign cur_mode = unpack_mode(mode_r);

    cmq_ctrl #(.ID_W(ID_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_id      (bus_id),
        .mode_wr    (wr_fire && hit_mode),
        .need_addr  (new_mode.region == RG_RANGE),
        .need_ways  (new_mode.region == RG_WAY || new_mode.dest == DS_WAY),
        .addr_wr    (wr_fire && hit_addr),
        .size_wr    (wr_fire && hit_size),
        .ways_wr    (wr_fire && hit_ways),
        .mask_wr    (wr_fire && hit_mask),
        .notify     (cur_mode.notify),
        .arr_done   (arr_done),
        .ef_clr     (wr_fire && hit_stat && bus_wdata[2]),
        .mode_grant (mode_grant),
        .mode_deny  (mode_deny),
        .param_take (param_take),
        .param_deny (param_deny),
        .arr_start  (arr_start),
        .est        (est),
        .qst        (qst),
        .ef         (ef)
    );

    cmq_flags #(.NUM_MASTERS(NUM_MASTERS), .ID_W(ID_W)) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .id       (bus_id),
        .set_oe   (mode_deny),
        .set_fe   (param_deny),
        .clr      (mode_grant),
        .rd_flags (rd_flags)
    );

    cmq_prim u_prim (
        .clk        (clk),
        .rst_n      (rst_n),
        .prim_wr    (wr_fire && hit_prim),
        .wr_code    (bus_wdata[3:0]),
        .prim_done  (prim_done),
        .prim_start (prim_start),
        .prim_code  (prim_code),
        .busy       (prim_busy)
    );

    // programmed registers, written only on accepted owner writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_r    <= '0;
            addr_r    <= '0;
            size_r    <= '0;
            mask_r    <= '0;
            ways_r    <= '0;
            prim_last <= '0;
        end else begin
            if (mode_grant)             mode_r <= bus_wdata;
            if (param_take && hit_addr) addr_r <= bus_wdata;
            if (param_take && hit_size) size_r <= bus_wdata;
            if (param_take && hit_mask) mask_r <= bus_wdata;
            if (param_take && hit_ways) ways_r <= bus_wdata[NUM_WAYS-1:0];
            if (wr_fire && hit_prim)    prim_last <= bus_wdata[3:0];
        end
    end

    always_comb begin
        arr_cmd    = cur_mode.cmd;
        arr_region = cur_mode.region;
        arr_dest   = cur_mode.dest;
        arr_addr   = addr_r;
        arr_size   = size_r;
        arr_mask   = mask_r;
        arr_ways   = ways_r;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (ofs)
            OFS_PRIM:  bus_rdata = {28'h0, prim_last};
            OFS_MODE:  bus_rdata = mode_r;
            OFS_ADDR:  bus_rdata = addr_r;
            OFS_SIZE:  bus_rdata = size_r;
            OFS_MASK:  bus_rdata = mask_r;
            OFS_WAYS:  bus_rdata = {{WAY_PAD{1'b0}}, ways_r};
            OFS_FLAGS: bus_rdata = {30'h0, rd_flags};
            OFS_STAT:  bus_rdata = {29'h0, ef, est, qst};
            default:   bus_rdata = '0;
        endcase
    end

    // R10
    stall_only_prim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |-> hit_prim);

    // R3
    issue_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |-> $past(wr_fire));

    // R9
    prim_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prim_start |-> $past(wr_fire && hit_prim));

endmodule

// File: tb/tb_cache_maint_queue.sv
module tb_cache_maint_queue;
    import cmq_pkg::*;

    localparam int CLK_PERIOD  = 10;
    localparam int NUM_MASTERS = 4;
    localparam int ID_W        = 2;
    localparam int NUM_WAYS    = 8;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                bus_req = 1'b0, bus_we = 1'b0;
    logic [ID_W-1:0]     bus_id = '0;
    logic [11:0]         bus_addr = '0;
    logic [31:0]         bus_wdata = '0;
    logic                bus_ack;
    logic [31:0]         bus_rdata;
    logic                arr_start;
    logic [2:0]          arr_cmd;
    logic [1:0]          arr_region, arr_dest;
    logic [31:0]         arr_addr, arr_size, arr_mask;
    logic [NUM_WAYS-1:0] arr_ways;
    logic                arr_done = 1'b0;
    logic                prim_start;
    logic [3:0]          prim_code;
    logic                prim_done = 1'b0;

    int tests = 0, fails = 0;
    int op_cnt = 0, pr_cnt = 0, done_lat = 6, prim_lat = 5;

    always #(CLK_PERIOD/2) clk = ~clk;

    cache_maint_queue #(.NUM_MASTERS(NUM_MASTERS), .ID_W(ID_W), .NUM_WAYS(NUM_WAYS), .OFS_W(12)) dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_id(bus_id),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .arr_start(arr_start), .arr_cmd(arr_cmd), .arr_region(arr_region), .arr_dest(arr_dest),
        .arr_addr(arr_addr), .arr_size(arr_size), .arr_mask(arr_mask), .arr_ways(arr_ways),
        .arr_done(arr_done), .prim_start(prim_start), .prim_code(prim_code), .prim_done(prim_done));

    // cache array model: answers each request after a set latency
    always @(negedge clk) begin
        arr_done  = 1'b0;
        prim_done = 1'b0;
        if (op_cnt > 0) begin op_cnt--; if (op_cnt == 0) arr_done = 1'b1; end
        if (pr_cnt > 0) begin pr_cnt--; if (pr_cnt == 0) prim_done = 1'b1; end
        if (arr_start)  op_cnt = done_lat;
        if (prim_start) pr_cnt = prim_lat;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int id, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_id = ID_W'(id); bus_addr = a; bus_wdata = d;
        #1;
        while (!bus_ack) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input int id, input logic [11:0] a, output logic [31:0] d, output int stall);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_id = ID_W'(id); bus_addr = a;
        stall = 0;
        #1;
        while (!bus_ack) begin stall++; @(negedge clk); #1; end
        d = bus_rdata;
        @(posedge clk); #1;
        bus_req = 1'b0;
    endtask

    typedef struct packed {
        logic [31:0] mode;
        logic [31:0] addr;
        logic [31:0] size;
        logic [31:0] ways;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{32'h0000_8000, 32'h1000_0000, 32'h0000_0200, 32'h0000_0000},
        '{32'h0002_8001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
        '{32'h0004_8002, 32'h0000_0000, 32'h0000_0000, 32'h0000_000F},
        '{32'h0040_8005, 32'h2000_0080, 32'h0000_0100, 32'h0000_00F0},
        '{32'h0020_0003, 32'h3000_0000, 32'h0000_0080, 32'h0000_0000},
        '{32'h0042_8006, 32'h0000_0000, 32'h0000_0000, 32'h0000_003C}
    };

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int st;
        int starts;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(0, OFS_STAT, d, st);  chk("R1 status", d, 0);
        rd(2, OFS_FLAGS, d, st); chk("R1 flags", d, 0);
        chk("R1 no start", {arr_start, prim_start}, 0);

        // R2 R3 R7 R8 R12 table of modes
        foreach (VECS[i]) begin
            automatic vec_t v = VECS[i];
            automatic logic na = (v.mode[18:17] == 2'd0);
            automatic logic nw = (v.mode[18:17] == 2'd2) || (v.mode[22:21] == 2'd2);
            automatic int id = i % NUM_MASTERS;
            wr(id, OFS_MODE, v.mode);
            if (na) begin
                wr(id, OFS_ADDR, v.addr);
                if (nw) wr(id, OFS_SIZE, v.size);
            end
            if (na || nw) begin
                chk("R3 no early start", {31'h0, arr_start}, 0);
                if (nw) wr(id, OFS_WAYS, v.ways);
                else    wr(id, OFS_SIZE, v.size);
            end
            chk("R3 start", {31'h0, arr_start}, 1);
            chk("R2 cmd", {29'h0, arr_cmd}, {29'h0, v.mode[2:0]});
            chk("R2 region/dest", {28'h0, arr_region, arr_dest}, {28'h0, v.mode[18:17], v.mode[22:21]});
            if (na) chk("R3 addr/size", arr_addr ^ arr_size, v.addr ^ v.size);
            if (nw) chk("R3 ways", {24'h0, arr_ways}, v.ways);
            rd(id, OFS_STAT, d, st); chk("R8 in flight", d & 3, 3);
            repeat (10) @(negedge clk);
            rd(id, OFS_STAT, d, st); chk("R7 R8 after done", d, {29'h0, v.mode[15], 2'b00});
            rd(id, OFS_MODE, d, st); chk("R12 mode readback", d, v.mode);
            wr(id, OFS_STAT, 32'h4);
        end

        // R4 R5 R6 competing masters
        done_lat = 30;
        wr(1, OFS_MODE, 32'h0000_8000);
        wr(2, OFS_MODE, 32'h0002_8001);
        rd(2, OFS_FLAGS, d, st); chk("R4 overrun in setup", d, 1);
        wr(2, OFS_ADDR, 32'hDEAD_0000);
        rd(2, OFS_FLAGS, d, st); chk("R5 setup fault", d, 3);
        rd(1, OFS_FLAGS, d, st); chk("R6 owner flags clean", d, 0);
        wr(1, OFS_ADDR, 32'h0000_4000);
        wr(1, OFS_SIZE, 32'h0000_0100);
        chk("R5 owner addr kept", arr_addr, 32'h0000_4000);
        chk("R3 start after owner", {31'h0, arr_start}, 1);
        wr(3, OFS_MODE, 32'h0002_8001);
        rd(3, OFS_FLAGS, d, st); chk("R4 overrun in flight", d, 1);
        starts = 0;
        for (int k = 0; k < 35; k++) begin @(negedge clk); #1; if (arr_start) starts++; end
        chk("R4 rejected mode ignored", starts, 0);

        // R7 write-one-to-clear
        rd(1, OFS_STAT, d, st); chk("R7 set", d, 4);
        wr(1, OFS_STAT, 32'h3);
        rd(1, OFS_STAT, d, st); chk("R7 zero write keeps", d, 4);
        wr(1, OFS_STAT, 32'h4);
        rd(1, OFS_STAT, d, st); chk("R7 cleared", d, 0);

        // R6 flags cleared on granted retry, R2 whole-cache issues at once
        done_lat = 4;
        wr(3, OFS_MODE, 32'h0002_0001);
        chk("R2 immediate issue", {31'h0, arr_start}, 1);
        rd(3, OFS_FLAGS, d, st); chk("R6 retry clears", d, 0);
        repeat (8) @(negedge clk);
        rd(3, OFS_STAT, d, st); chk("R7 no notify", d, 0);

        // R11 owner restart drops old needs
        wr(0, OFS_MODE, 32'h0000_8000);
        wr(0, OFS_ADDR, 32'h0000_5000);
        wr(0, OFS_MODE, 32'h0004_8002);
        chk("R11 no start yet", {31'h0, arr_start}, 0);
        wr(0, OFS_WAYS, 32'h0000_0001);
        chk("R11 start", {31'h0, arr_start}, 1);
        chk("R11 region way", {30'h0, arr_region}, 2);
        chk("R11 ways", {24'h0, arr_ways}, 1);
        repeat (8) @(negedge clk);
        wr(0, OFS_STAT, 32'h4);

        // R9 R10 primitive register
        wr(0, OFS_PRIM, 32'h8);
        chk("R9 drain start", {27'h0, prim_start, prim_code}, {27'h0, 1'b1, 4'h8});
        rd(0, OFS_PRIM, d, st);
        chk("R10 readback", d, 8);
        chk("R10 stalled", {31'h0, st >= 3}, 1);
        wr(0, OFS_PRIM, 32'h3);
        chk("R9 other code", {31'h0, prim_start}, 0);
        rd(0, OFS_PRIM, d, st);
        chk("R10 no stall", st, 0);
        chk("R10 last code", d, 3);
        wr(1, OFS_PRIM, 32'h9);
        chk("R9 flush start", {27'h0, prim_start, prim_code}, {27'h0, 1'b1, 4'h9});
        repeat (8) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule